// File: doc/BRIEF.md
# Raster Sync and Blank Timing Generator

This block drives the sync, blanking and display-enable outputs of a raster display. It steps through one character position per clock, where one character stands for eight pixels, and it counts scan lines. It also supplies the memory address of the first pixel that is shown. Software sets it up through an index/data register pair. A write on the index port chooses one of sixteen byte registers. A write on the data port loads the chosen register. The same chosen register can always be read back.

Vertical values are 11 bits wide and the start address is 20 bits wide. Their upper bits sit in shared overflow registers, and the block joins them back into full fields. Vertical timing is set in scan lines. In double-scan mode each line count lasts for two line periods. A newly written start address is not used at once: it is latched when vertical blanking begins, so a frame never shows two bases.

The vertical region is tracked by a three-state machine. The states are `V_DISP` (visible lines), `V_GAP` (past the last visible line but before blanking) and `V_BLANK` (vertical blanking). Moves between states happen only on a line step, and the new state depends on the next line number:
- DISP to GAP: the next line is past display end.
- DISP or GAP to BLANK: the next line reaches blank start. This move also loads the start address.
- GAP or BLANK to DISP: the line count wraps back into the visible range.
- BLANK to GAP: blank start is moved above the next line.

Top module: `crtc_timing_gen`

## Requirements
- R1: A write with `cfg_sel`=0 loads the low 4 bits of `cfg_wdata` as the register index. A write with `cfg_sel`=1 stores `cfg_wdata` into the indexed register. `cfg_rdata` always shows the indexed register. Register indices: 0 horizontal total, 1 horizontal display end, 2 horizontal sync start, 3 horizontal sync end (bits 4:0), 4 vertical total, 5 vertical display end, 6 vertical sync start, 7 vertical sync end (bits 3:0), 8 vertical blank start, 9 vertical overflow, 10 vertical extension, 11 scan control, 12 start low, 13 start high, 14 start bit-16 register, 15 start upper register.
- R2: The character counter runs from 0 to the horizontal total value (register 0) and then returns to 0, so a line lasts total+1 clocks. The line counter changes only when the character counter wraps.
- R3: `hblank_o` is high exactly while the character count is greater than the display-end value, so blanking starts at display end + 1 and lasts until the line wraps.
- R4: Horizontal sync becomes active when the character count reaches sync start. It ends when the low 5 bits of the count equal the sync-end field. Start takes priority if both match.
- R5: The 11-bit vertical fields are assembled as follows. Total is {ext[7], ovf[5], ovf[0], reg4}. Display end is {ext[4], ovf[6], ovf[1], reg5}. Sync start is {ext[5], ovf[7], ovf[2], reg6}. Blank start is {ext[6], scan[5], ovf[3], reg8}. Here ovf is register 9, ext is register 10 and scan is register 11. A frame lasts (total+1) line steps.
- R6: `vblank_o` goes high on the line step that reaches blank start and stays high until the line count wraps back below it.
- R7: Vertical sync becomes active on the line step that reaches sync start. It ends on the line step whose low 4 line bits equal the 4-bit sync-end field.
- R8: `de_o` is high only when the line is at or below display end and the character count is at or below its display end. It is low whenever either blank is high.
- R9: The start address is {reg15[2:0], reg14[5], reg13, reg12}. `start_addr_o` changes only on the clock where `vblank_o` rises, and it then takes the value the registers held.
- R10: With scan-control bit 7 set, each line count lasts two line periods. All vertical timings, including sync width, therefore double.
- R11: After reset, all registers and counters are zero. `hsync_o`, `vsync_o` and `vblank_o` are low, and `start_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Contents of the indexed register |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Display enable |
| start_addr_o | output | 20 | Address of the first displayed pixel |

## Verification
The bench sets line counts whose bits 8, 9 and 10 are each set in some frame. A mis-wired overflow bit then shows up as a wrong frame length or a misplaced blank. It rewrites the start address in the middle of the visible area and checks that the output holds its old value until blanking rises. A design that copies the address straight through would change it mid-frame. Sync widths are measured with double scan on and with it off. A design that doubled only the line counter, but not the sync-end compare timing, would give a pulse of the wrong length. A reference model compares every output on every cycle, including across reconfigurations made while the raster is running.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int IDX_W = 4;
    localparam int NREG  = 1 << IDX_W;
    localparam int DW    = 8;
    localparam int HW    = 8;
    localparam int HSE_W = 5;
    localparam int VW    = 11;
    localparam int VSE_W = 4;
    localparam int SAW   = 20;

    localparam int RI_HTOT  = 0;
    localparam int RI_HDE   = 1;
    localparam int RI_HSS   = 2;
    localparam int RI_HSE   = 3;
    localparam int RI_VTOT  = 4;
    localparam int RI_VDE   = 5;
    localparam int RI_VSS   = 6;
    localparam int RI_VSE   = 7;
    localparam int RI_VBS   = 8;
    localparam int RI_VOVF  = 9;
    localparam int RI_VEXT  = 10;
    localparam int RI_SCAN  = 11;
    localparam int RI_SALO  = 12;
    localparam int RI_SAHI  = 13;
    localparam int RI_SA16  = 14;
    localparam int RI_SATOP = 15;

    typedef struct packed {
        logic [HW-1:0]    htot;
        logic [HW-1:0]    hde;
        logic [HW-1:0]    hss;
        logic [HSE_W-1:0] hse;
        logic [VW-1:0]    vtot;
        logic [VW-1:0]    vde;
        logic [VW-1:0]    vss;
        logic [VW-1:0]    vbs;
        logic [VSE_W-1:0] vse;
        logic             dbl;
        logic [SAW-1:0]   start;
    } timing_t;

    typedef enum logic [1:0] {
        V_DISP  = 2'd0,
        V_GAP   = 2'd1,
        V_BLANK = 2'd2
    } vstate_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int NR = NREG,
    parameter int W  = DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                sel,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        rdata,
    output logic [NR-1:0][W-1:0] regs
);
    logic [IW-1:0] idx_q;

    // index port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (wr && !sel)
            idx_q <= wdata[IW-1:0];
    end

    // data registers, one per index
    for (genvar g = 0; g < NR; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr && sel && (idx_q == IW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx_q];
endmodule

// File: rtl/crtc_field_join.sv
module crtc_field_join
    import crtc_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] regs,
    output timing_t                 tcfg
);
    logic [DW-1:0] ovf, ext, scan, s16, stop;
    logic          unused_bits;

    assign ovf  = regs[RI_VOVF];
    assign ext  = regs[RI_VEXT];
    assign scan = regs[RI_SCAN];
    assign s16  = regs[RI_SA16];
    assign stop = regs[RI_SATOP];

    always_comb begin
        tcfg.htot  = regs[RI_HTOT];
        tcfg.hde   = regs[RI_HDE];
        tcfg.hss   = regs[RI_HSS];
        tcfg.hse   = regs[RI_HSE][HSE_W-1:0];
        tcfg.vtot  = {ext[7], ovf[5], ovf[0], regs[RI_VTOT]};
        tcfg.vde   = {ext[4], ovf[6], ovf[1], regs[RI_VDE]};
        tcfg.vss   = {ext[5], ovf[7], ovf[2], regs[RI_VSS]};
        tcfg.vbs   = {ext[6], scan[5], ovf[3], regs[RI_VBS]};
        tcfg.vse   = regs[RI_VSE][VSE_W-1:0];
        tcfg.dbl   = scan[7];
        tcfg.start = {stop[2:0], s16[5], regs[RI_SAHI], regs[RI_SALO]};
    end

    assign unused_bits = ^{ext[3:0], ovf[4], scan[6], scan[4:0], s16[7:6],
                           s16[4:0], stop[7:3], regs[RI_HSE][DW-1:HSE_W],
                           regs[RI_VSE][DW-1:VSE_W]};
endmodule

// File: rtl/crtc_raster.sv
module crtc_raster
    import crtc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  timing_t        cfg,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           hblank_o,
    output logic           vblank_o,
    output logic           de_o,
    output logic [SAW-1:0] start_o,
    output logic [HW-1:0]  hcnt_o,
    output logic [VW-1:0]  vcnt_o
);
    logic [HW-1:0]  hcnt, h_nx;
    logic [VW-1:0]  vcnt, v_nx;
    logic           hs_q, hs_nx, vs_q, vs_nx, scan_q, scan_nx;
    logic           line_end, line_step;
    vstate_t        st, st_nx;
    logic [SAW-1:0] sa_q, sa_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            vcnt   <= '0;
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
            scan_q <= 1'b0;
            st     <= V_DISP;
            sa_q   <= '0;
        end else begin
            hcnt   <= h_nx;
            vcnt   <= v_nx;
            hs_q   <= hs_nx;
            vs_q   <= vs_nx;
            scan_q <= scan_nx;
            st     <= st_nx;
            sa_q   <= sa_nx;
        end
    end

    // next state
    always_comb begin
        line_end = (hcnt == cfg.htot);
        h_nx     = line_end ? '0 : hcnt + 1'b1;
        hs_nx    = hs_q;
        if (h_nx == cfg.hss)
            hs_nx = 1'b1;
        else if (h_nx[HSE_W-1:0] == cfg.hse)
            hs_nx = 1'b0;

        scan_nx   = cfg.dbl ? (scan_q ^ line_end) : 1'b0;
        line_step = line_end && (!cfg.dbl || scan_q);

        v_nx  = vcnt;
        vs_nx = vs_q;
        st_nx = st;
        sa_nx = sa_q;
        if (line_step) begin
            v_nx = (vcnt == cfg.vtot) ? '0 : vcnt + 1'b1;
            if (v_nx == cfg.vss)
                vs_nx = 1'b1;
            else if (v_nx[VSE_W-1:0] == cfg.vse)
                vs_nx = 1'b0;

            unique case (st)
                V_DISP: begin
                    if (v_nx >= cfg.vbs)     st_nx = V_BLANK;
                    else if (v_nx > cfg.vde) st_nx = V_GAP;
                end
                V_GAP: begin
                    if (v_nx >= cfg.vbs)       st_nx = V_BLANK;
                    else if (v_nx <= cfg.vde)  st_nx = V_DISP;
                end
                V_BLANK: begin
                    if (v_nx < cfg.vbs)
                        st_nx = (v_nx > cfg.vde) ? V_GAP : V_DISP;
                end
                default: st_nx = V_DISP;
            endcase

            if (st_nx == V_BLANK && st != V_BLANK)
                sa_nx = cfg.start;
        end
    end

    // outputs
    always_comb begin
        hblank_o = (hcnt > cfg.hde);
        vblank_o = (st == V_BLANK);
        de_o     = !hblank_o && (st == V_DISP);
        hsync_o  = hs_q;
        vsync_o  = vs_q;
        start_o  = sa_q;
        hcnt_o   = hcnt;
        vcnt_o   = vcnt;
    end
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic           cfg_sel,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           hblank_o,
    output logic           vblank_o,
    output logic           de_o,
    output logic [19:0]    start_addr_o
);
    logic [NREG-1:0][DW-1:0] regs_w;
    timing_t                 tcfg;
    logic [HW-1:0]           hcnt_w;
    logic [VW-1:0]           vcnt_w;

    crtc_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .regs  (regs_w)
    );

    crtc_field_join u_join (
        .regs (regs_w),
        .tcfg (tcfg)
    );

    crtc_raster u_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (tcfg),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .hblank_o (hblank_o),
        .vblank_o (vblank_o),
        .de_o     (de_o),
        .start_o  (start_addr_o),
        .hcnt_o   (hcnt_w),
        .vcnt_o   (vcnt_w)
    );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           hsync_o,
    input logic           vsync_o,
    input logic           hblank_o,
    input logic           vblank_o,
    input logic           de_o,
    input logic [SAW-1:0] start_addr_o,
    input logic [HW-1:0]  hcnt,
    input logic [VW-1:0]  vcnt,
    input logic [HW-1:0]  htot,
    input logic [HW-1:0]  hss,
    input logic [VW-1:0]  vss
);
    AST_DE_LOW_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_o |-> !de_o); // R8
    AST_DE_LOW_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_o |-> !de_o); // R8
    AST_START_ONLY_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(start_addr_o) |-> $rose(vblank_o)); // R9
    AST_HSYNC_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> (hcnt == $past(hss))); // R4
    AST_VSYNC_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> (vcnt == $past(vss))); // R7
    AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hcnt) == $past(htot)) |-> (hcnt == '0)); // R2
    AST_VCNT_ON_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcnt) |-> ($past(hcnt) == $past(htot))); // R2
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .hblank_o     (hblank_o),
    .vblank_o     (vblank_o),
    .de_o         (de_o),
    .start_addr_o (start_addr_o),
    .hcnt         (hcnt_w),
    .vcnt         (vcnt_w),
    .htot         (tcfg.htot),
    .hss          (tcfg.hss),
    .vss          (tcfg.vss)
);

// File: tb/crtc_timing_gen_tb_top.sv
`timescale 1ns/1ps
module crtc_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        hsync_o, vsync_o, hblank_o, vblank_o, de_o;
    logic [19:0] start_addr_o;

    always #2.5 clk = ~clk;

    crtc_timing_gen dut_i (.*);

    int errors = 0, checks = 0, cyc = 0;
    bit cmp_en = 1'b0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int mreg[16];
    int midx, mh, mv, mst, mstart;
    bit mhs, mvs, mscan;

    function automatic int hb(int r, int b);
        return (mreg[r] >> b) & 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mreg[i]) mreg[i] = 0;
            midx = 0; mh = 0; mv = 0; mst = 0; mstart = 0;
            mhs = 0; mvs = 0; mscan = 0;
        end else begin
            int vtot, vde, vss, vbs, st_new;
            bit dbl, wrap, stepv;
            vtot = mreg[4] + 256*hb(9,0) + 512*hb(9,5) + 1024*hb(10,7);
            vde  = mreg[5] + 256*hb(9,1) + 512*hb(9,6) + 1024*hb(10,4);
            vss  = mreg[6] + 256*hb(9,2) + 512*hb(9,7) + 1024*hb(10,5);
            vbs  = mreg[8] + 256*hb(9,3) + 512*hb(11,5) + 1024*hb(10,6);
            dbl  = hb(11,7) == 1;
            wrap = (mh == mreg[0]);
            mh   = wrap ? 0 : (mh + 1) % 256;
            if (mh == mreg[2]) mhs = 1;
            else if ((mh % 32) == (mreg[3] % 32)) mhs = 0;
            stepv = wrap && (!dbl || mscan);
            if (dbl) begin
                if (wrap) mscan = !mscan;
            end else mscan = 0;
            if (stepv) begin
                mv = (mv == vtot) ? 0 : (mv + 1) % 2048;
                if (mv == vss) mvs = 1;
                else if ((mv % 16) == (mreg[7] % 16)) mvs = 0;
                st_new = (mv >= vbs) ? 2 : ((mv > vde) ? 1 : 0);
                if (st_new == 2 && mst != 2)
                    mstart = mreg[12] + 256*mreg[13] + 65536*hb(14,5) + 131072*(mreg[15] & 7);
                mst = st_new;
            end
            if (cfg_wr) begin
                if (cfg_sel) mreg[midx] = int'(cfg_wdata);
                else         midx = int'(cfg_wdata) & 15;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            bit ehb;
            ehb = mh > mreg[1];
            check(hblank_o == ehb, "R3 hblank", hblank_o, ehb);
            check(hsync_o == mhs, "R4 hsync", hsync_o, mhs);
            check(vsync_o == mvs, "R7 vsync", vsync_o, mvs);
            check(vblank_o == (mst == 2), "R6 vblank", vblank_o, mst == 2);
            check(de_o == (!ehb && mst == 0), "R8 de", de_o, !ehb && mst == 0);
            check(start_addr_o == 20'(mstart), "R9 start", start_addr_o, mstart);
            check(cfg_rdata == 8'(mreg[midx]), "R1 rdata", cfg_rdata, mreg[midx]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(int idx, int val);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'(idx);
        @(negedge clk); cfg_sel = 1'b1; cfg_wdata = 8'(val);
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic setup(int ht, int hd, int hs, int he, int vt, int vd,
                         int vs, int ve, int vb, bit dbl);
        int ovf, ext, scn;
        ovf = ((vt>>8)&1) | (((vd>>8)&1)<<1) | (((vs>>8)&1)<<2) | (((vb>>8)&1)<<3)
            | (((vt>>9)&1)<<5) | (((vd>>9)&1)<<6) | (((vs>>9)&1)<<7);
        ext = (((vd>>10)&1)<<4) | (((vs>>10)&1)<<5) | (((vb>>10)&1)<<6) | (((vt>>10)&1)<<7);
        scn = (dbl ? 128 : 0) | (((vb>>9)&1)<<5);
        put(0, ht); put(1, hd); put(2, hs); put(3, he);
        put(4, vt & 255); put(5, vd & 255); put(6, vs & 255); put(7, ve);
        put(8, vb & 255); put(9, ovf); put(10, ext); put(11, scn);
    endtask

    task automatic set_start(int a);
        put(12, a & 255); put(13, (a >> 8) & 255);
        put(14, ((a >> 16) & 1) << 5); put(15, (a >> 17) & 7);
    endtask

    function automatic bit sig(int which);
        return (which == 0) ? vsync_o : vblank_o;
    endfunction

    task automatic wait_for(int which, bit lvl);
        int n = 0;
        while (sig(which) != lvl && n < 20000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic high_len(int which, output int len);
        wait_for(which, 1'b0); wait_for(which, 1'b1);
        len = 0;
        while (sig(which) && len < 20000) begin
            @(negedge clk); len++;
        end
    endtask

    task automatic period(int which, output int len);
        wait_for(which, 1'b0); wait_for(which, 1'b1);
        len = 0;
        wait_for(which, 1'b0);
        while (!sig(which) && len < 20000) begin
            @(negedge clk); len++;
        end
        len += 0;
    endtask

    task automatic frame_len(output int len);
        int n;
        wait_for(1, 1'b0); wait_for(1, 1'b1);
        n = 0;
        while (vblank_o && n < 20000) begin @(negedge clk); n++; end
        while (!vblank_o && n < 20000) begin @(negedge clk); n++; end
        len = n;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int len;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(hsync_o == 1'b0, "R11 hsync reset", hsync_o, 0);
        check(vsync_o == 1'b0, "R11 vsync reset", vsync_o, 0);
        check(vblank_o == 1'b0, "R11 vblank reset", vblank_o, 0);
        check(start_addr_o == '0, "R11 start reset", start_addr_o, 0);
        check(cfg_rdata == '0, "R11 rdata reset", cfg_rdata, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // config A: 20 chars/line, 301 lines, bit 8 of every vertical field
        setup(19, 11, 14, 17, 300, 259, 270, 1, 264, 1'b0);
        put(2, 14);
        check(cfg_rdata == 8'd14, "R1 readback", cfg_rdata, 14);
        frame_len(len);
        check(len == 301*20, "R5 frame length A", len, 301*20);
        high_len(0, len);
        check(len == 3*20, "R7 vsync width A", len, 3*20);

        // R9: start address written mid-frame held until blank
        wait_for(1, 1'b0);
        set_start(20'h5A3C1);
        check(start_addr_o == 20'h0, "R9 start held", start_addr_o, 0);
        wait_for(1, 1'b1);
        check(start_addr_o == 20'h5A3C1, "R9 start taken", start_addr_o, 20'h5A3C1);

        // config B: bits 9 and 10 of the vertical fields
        setup(3, 1, 2, 3, 1600, 1023, 1560, 11, 1540, 1'b0);
        frame_len(len);
        frame_len(len);
        check(len == 1601*4, "R5 frame length B", len, 1601*4);
        wait_for(1, 1'b0);
        set_start(20'hE0F12);
        check(start_addr_o == 20'h5A3C1, "R9 start held B", start_addr_o, 20'h5A3C1);
        wait_for(1, 1'b1);
        check(start_addr_o == 20'hE0F12, "R9 start taken B", start_addr_o, 20'hE0F12);

        // config C: double scan
        setup(3, 1, 2, 3, 9, 5, 8, 9, 7, 1'b1);
        frame_len(len);
        frame_len(len);
        check(len == 10*2*4, "R10 frame length double", len, 80);
        high_len(0, len);
        check(len == 2*4, "R10 vsync width double", len, 8);

        // same timing, single scan
        put(11, 0);
        frame_len(len);
        frame_len(len);
        check(len == 10*4, "R2 frame length single", len, 40);
        high_len(0, len);
        check(len == 4, "R7 vsync width single", len, 4);
        period(0, len);
        check(len == 9*4, "R7 vsync low time", len, 36);

        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule